// File: doc/BRIEF.md
# Dual-Enable Separate-I/O Static Memory Core

This block is a clocked functional model of a small static memory with separate input and output data buses. It has two active-low select pins, an active-low write strobe and an active-low output-drive request. On each rising clock edge the pin levels are sampled and decoded into one of four modes:

- idle, when either select is high;
- quiet, when selected but neither reading nor writing;
- read;
- write.

A write stores the input word into the array on that same edge. The registered output stage presents its result in the cycle that follows.

High impedance is modelled by a drive flag next to the output bus. Whenever the flag is low, the bus reads as zero. A build-time parameter picks how the outputs behave during a write. In write-through form, the incoming word is driven out while the drive request is low. In the isolated form, the outputs stay undriven for the whole write.

The depth is set by the address width. Fourteen address bits give the full 16,384-word by 4-bit organisation. The default build uses a smaller address width to keep elaboration light.

Top module: `sio_sram_core`

## Requirements
- R1: The array holds 2**ADDR_W independent words of DATA_W bits; 14 address bits give 16,384 words of 4 bits.
- R2: If either select (`sel_a_n` or `sel_b_n`) is high when sampled, the block is idle: no word is stored, and in the next cycle `rdata_vld_o` is 0.
- R3: When both selects are low, `wr_n` is high and `drv_n` is high, the mode is quiet: the array is unchanged and in the next cycle `rdata_vld_o` is 0.
- R4: When both selects are low, `wr_n` is high and `drv_n` is low, the mode is read: in the next cycle `rdata_vld_o` is 1 and `rdata_o` equals the word at the sampled address.
- R5: When both selects are low and `wr_n` is low, `wdata_i` is stored at the sampled address on that edge, whatever the level of `drv_n`.
- R6: With WRITE_THRU=1, a write sampled with `drv_n` low gives `rdata_vld_o`=1 and `rdata_o` equal to the written word in the next cycle; a write with `drv_n` high leaves the outputs undriven.
- R7: With WRITE_THRU=0, every write leaves `rdata_vld_o` at 0 in the next cycle.
- R8: If a select goes high in the same cycle that `wr_n` returns high, the following cycle shows `rdata_vld_o`=0 and `rdata_o`=0, with no transient drive of data.
- R9: Whenever `rdata_vld_o` is 0, `rdata_o` is all zeros; synchronous reset clears both outputs.
- R10: A read in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select |
| wr_n | input | 1 | Active-low write strobe |
| drv_n | input | 1 | Active-low output-drive request |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Output data, zero when not driven |
| rdata_vld_o | output | 1 | Output driven flag (low stands for high impedance) |

## Verification
All sixteen levels of the four control pins are applied at a fixed address. This shows that idle, quiet, read and write are decoded apart, and that a write with the drive request high is told apart from one with it low.

Both variants run side by side on the same stimulus, so write-through and isolated outputs are separated on every write cycle. A full-array fill and readback with an address-dependent pattern catches aliasing between words.

Directed sequences cover three further cases:
- a write attempted while deselected, which must leave the array unchanged;
- a select rising together with the write strobe's release;
- a read that immediately follows a write to the same address.

// File: rtl/sio_sram_pkg.sv
package sio_sram_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_QUIET = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  drv_req;
    } ctrl_t;

    function automatic mode_e pick_mode(input logic s_a_n, input logic s_b_n,
                                        input logic w_n, input logic d_n);
        if (s_a_n || s_b_n) return MODE_IDLE;
        if (!w_n)           return MODE_WRITE;
        if (!d_n)           return MODE_READ;
        return MODE_QUIET;
    endfunction

    function automatic logic lane_drives(input ctrl_t c, input logic thru);
        return (c.mode == MODE_READ) || (c.mode == MODE_WRITE && thru && c.drv_req);
    endfunction

endpackage

// File: rtl/sio_mode_decode.sv
module sio_mode_decode
    import sio_sram_pkg::*;
(
    input  logic  sel_a_n,
    input  logic  sel_b_n,
    input  logic  wr_n,
    input  logic  drv_n,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl.mode    = pick_mode(sel_a_n, sel_b_n, wr_n, drv_n);
        ctrl.drv_req = !drv_n;
    end
endmodule

// File: rtl/sio_array.sv
module sio_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_go;

    assign wr_go   = wr_en && !rst;
    assign rd_word = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_go) mem[addr] <= wdata;
    end

    // R10: word written last cycle is visible at the same address now
    assert_read_after_write_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_go) && !wr_go && addr == $past(addr)) |-> rd_word == $past(wdata));
endmodule

// File: rtl/sio_out_stage.sv
module sio_out_stage
    import sio_sram_pkg::*;
#(
    parameter int DATA_W     = 4,
    parameter bit WRITE_THRU = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_o,
    output logic              vld_o
);
    logic              drive;
    logic [DATA_W-1:0] next_data;

    always_comb begin
        drive = lane_drives(ctrl, WRITE_THRU);
        if (!drive)                        next_data = '0;
        else if (ctrl.mode == MODE_WRITE)  next_data = wdata;
        else                               next_data = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o  <= drive;
            data_o <= next_data;
        end
    end

    assert_idle_undriven_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_IDLE) |=> !vld_o);

    assert_quiet_undriven_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_QUIET) |=> !vld_o);

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_READ) |=> (vld_o && data_o == $past(rd_word)));

    assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> data_o == '0);

    generate
        if (WRITE_THRU) begin : g_thru
            assert_write_thru_R6: assert property (@(posedge clk) disable iff (rst)
                (ctrl.mode == MODE_WRITE && ctrl.drv_req) |=> (vld_o && data_o == $past(wdata)));
        end else begin : g_iso
            assert_write_isolated_R7: assert property (@(posedge clk) disable iff (rst)
                (ctrl.mode == MODE_WRITE) |=> !vld_o);
        end
    endgenerate
endmodule

// File: rtl/sio_sram_core.sv
module sio_sram_core
    import sio_sram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 4,
    parameter bit WRITE_THRU = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              wr_n,
    input  logic              drv_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_vld_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;

    sio_mode_decode u_dec (
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .wr_n    (wr_n),
        .drv_n   (drv_n),
        .ctrl    (ctrl)
    );

    assign wr_en = (ctrl.mode == MODE_WRITE);

    sio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .rd_word (rd_word)
    );

    sio_out_stage #(.DATA_W(DATA_W), .WRITE_THRU(WRITE_THRU)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .rd_word (rd_word),
        .wdata   (wdata_i),
        .data_o  (rdata_o),
        .vld_o   (rdata_vld_o)
    );

    // R8: a select rising as the write strobe releases yields no drive
    assert_release_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_n) && wr_n && (sel_a_n || sel_b_n)) |=> (!rdata_vld_o && rdata_o == '0));
endmodule

// File: tb/sio_sram_core_tb.sv
`timescale 1ns/1ps
module sio_sram_core_tb;
    localparam int AW = 10;
    localparam int DW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa_n = 1'b1, sb_n = 1'b1, w_n = 1'b1, d_n = 1'b1;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q_t, q_i;
    logic v_t, v_i;

    logic [DW-1:0] shadow [DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sio_sram_core #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b1)) u_dut (
        .clk(clk), .rst(rst), .sel_a_n(sa_n), .sel_b_n(sb_n), .wr_n(w_n), .drv_n(d_n),
        .addr_i(adr), .wdata_i(din), .rdata_o(q_t), .rdata_vld_o(v_t));

    sio_sram_core #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b0)) u_dut_iso (
        .clk(clk), .rst(rst), .sel_a_n(sa_n), .sel_b_n(sb_n), .wr_n(w_n), .drv_n(d_n),
        .addr_i(adr), .wdata_i(din), .rdata_o(q_i), .rdata_vld_o(v_i));

    task automatic check(input string req, input logic v, input logic [DW-1:0] d,
                         input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (v !== ev || d !== ed) begin
            failures++;
            $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h", req, v, d, ev, ed);
        end
    endtask

    // One sampled cycle on both variants, expectations from the requirements
    task automatic step(input logic a, input logic b, input logic w, input logic o,
                        input logic [AW-1:0] ad, input logic [DW-1:0] di, input string req);
        logic sel, ev_t, ev_i;
        logic [DW-1:0] ed_t, ed_i;
        sel = !a && !b;
        ev_t = 1'b0; ev_i = 1'b0; ed_t = '0; ed_i = '0;
        if (sel && !w) begin
            if (!o) begin ev_t = 1'b1; ed_t = di; end
        end else if (sel && !o) begin
            ev_t = 1'b1; ed_t = shadow[ad];
            ev_i = 1'b1; ed_i = shadow[ad];
        end
        @(negedge clk);
        sa_n = a; sb_n = b; w_n = w; d_n = o; adr = ad; din = di;
        @(posedge clk);
        #1;
        if (sel && !w) shadow[ad] = di;
        check({req, " thru"}, v_t, q_t, ev_t, ed_t);
        check({req, " iso"},  v_i, q_i, ev_i, ed_i);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset thru", v_t, q_t, 1'b0, '0);
        check("R9 reset iso",  v_i, q_i, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fill;
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 1'b0, logic'(i[0]), AW'(i), DW'((i * 7 + 3) ^ (i >> 4)),
                 "R5 R6 R7 fill write");
    endtask

    task automatic t_readback;
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b0, 1'b1, 1'b0, AW'(i), DW'(i), "R1 R4 readback");
    endtask

    task automatic t_combos;
        for (int c = 0; c < 16; c++) begin
            step(logic'(c[3]), logic'(c[2]), logic'(c[1]), logic'(c[0]), AW'(5),
                 DW'(15 - c), "R2 R3 R4 R5 combo");
            step(1'b0, 1'b0, 1'b1, 1'b0, AW'(5), 4'h0, "R2 R3 R5 combo readback");
        end
    endtask

    task automatic t_ignored;
        step(1'b0, 1'b0, 1'b0, 1'b1, AW'(9), 4'h6, "R5 write with drive high");
        step(1'b1, 1'b0, 1'b0, 1'b0, AW'(9), 4'h9, "R2 deselected write a");
        step(1'b0, 1'b1, 1'b0, 1'b0, AW'(9), 4'hA, "R2 deselected write b");
        step(1'b0, 1'b0, 1'b1, 1'b1, AW'(9), 4'hB, "R3 quiet cycle");
        step(1'b0, 1'b0, 1'b1, 1'b0, AW'(9), 4'h0, "R2 R3 read unchanged");
    endtask

    task automatic t_release;
        step(1'b0, 1'b0, 1'b0, 1'b0, AW'(12), 4'hC, "R6 R7 write drive low");
        step(1'b0, 1'b1, 1'b1, 1'b0, AW'(12), 4'h3, "R8 select b rises on release");
        step(1'b0, 1'b0, 1'b0, 1'b0, AW'(13), 4'h5, "R6 R7 write drive low");
        step(1'b1, 1'b0, 1'b1, 1'b0, AW'(13), 4'h3, "R8 select a rises on release");
    endtask

    task automatic t_back_to_back;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, 1'b0, logic'(k[0]), AW'(100 + k), DW'(k * 5 + 1), "R10 write");
            step(1'b0, 1'b0, 1'b1, 1'b0, AW'(100 + k), 4'h0, "R10 read next cycle");
        end
    endtask

    initial begin
        t_reset();
        t_fill();
        t_readback();
        t_combos();
        t_ignored();
        t_release();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule